// File: doc/BRIEF.md
# Converter Power-Mode and Reset Controller

This block sits between a converter's register interface and its decimation filter. It decides which parts of a single-channel converter back end are powered, clocked and allowed to deliver results. It holds a small configuration file with four registers: a mode word, a phase-delay value, a bias-settling count and a filter-settling count. From the mode word it derives the bias enable, the core clock-gate enable, the internal-reference enable and the two supply-monitor enables. The filter's result word and its ready strobe pass through a registered output stage. That stage zeroes the data and blocks the strobe whenever the converter is powered down or in reset.

Three power situations are kept apart. A hard reset, taken from an active-low pin, wipes the configuration and the data and holds the filter in reset. An ADC shutdown stops the converter but keeps every setting, including the phase delay. A full shutdown, selected by a particular combination of mode bits, also turns off the reference and the supply monitors. After every wake-up a settling timer runs. It blocks results until the filter has settled, and it marks as suspect those results that arrive before the analog biases have settled.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While `hrst_n` is low, the outputs take these values at once, without waiting for a clock edge: `comp_state` = 4'b0011, `cfg_ready` = 0, `drdy` = 0, `dout` = 0 and `filt_rst` = 1.
- R2: After `hrst_n` rises, the block stays in reset until the second rising clock edge. It then reads back its defaults: mode 0, phase 0, bias count CORE_HZ/1000 and filter count FILT_SETTLE_DEF. A write attempted while `hrst_n` is low has no effect.
- R3: The register map is as follows. Address 0 is the mode word: bits [1:0] hold the shutdown field, bit 2 selects the external reference and bit 3 selects the external clock. Address 1 is the phase delay, which also drives `phase_out`. Address 2 is the bias-settling count and address 3 is the filter-settling count. A write takes effect on the clock edge that samples `cfg_wr` high, and `cfg_rdata` follows `cfg_addr` without a clock.
- R4: The converter is in ADC shutdown whenever the shutdown field is non-zero. In that state `dout` reads as zero, `drdy` stays low even when filter strobes arrive, and `bias_en` and `clk_gate_en` are 0. Both enables return to 1 as soon as the field is cleared.
- R5: Entering and leaving ADC shutdown leaves all register contents and `phase_out` unchanged.
- R6: Full shutdown holds exactly when shutdown bit 0, the external-reference bit and the external-clock bit are all 1. In full shutdown, `iref_en`, `mon_avdd_en` and `mon_dvdd_en` are 0. In every other mode all three are 1.
- R7: Call the clock edge that clears the shutdown field (or ends a hard reset) the wake edge. Number the edges after it k = 1, 2, and so on. A filter strobe sampled on edge k is passed on only if k > F, where F is the filter-settling count.
- R8: A passed strobe raises `data_suspect` with it when k ≤ B + F, where B is the bias-settling count. Strobes passed after that point leave `data_suspect` at 0.
- R9: In normal operation, a filter strobe sampled on one edge appears on `drdy` for exactly one cycle after that edge, with its data on `dout`. `dout` keeps that value until the next passed strobe.
- R10: Outside hard reset, `comp_state` follows `mod_comp`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| hrst_n | input | 1 | Active-low hard reset; asserts asynchronously, released through a synchronizer |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | REG_W | Register write data |
| cfg_rdata | output | REG_W | Register read data for `cfg_addr` |
| cfg_ready | output | 1 | Register interface accepts access |
| mod_comp | input | 4 | Comparator state from the modulator |
| comp_state | output | 4 | Comparator state toward the filter |
| filt_data | input | DATA_W | Filter result word |
| filt_drdy | input | 1 | Filter result strobe |
| filt_rst | output | 1 | Holds the filter and its output buffers in reset |
| dout | output | DATA_W | Gated result word |
| drdy | output | 1 | Gated result strobe |
| data_suspect | output | 1 | Result arrived inside the bias-settling window |
| phase_out | output | PH_W | Programmed phase delay |
| bias_en | output | 1 | Analog bias enable |
| clk_gate_en | output | 1 | Core clock-gate enable |
| iref_en | output | 1 | Internal reference enable |
| mon_avdd_en | output | 1 | Analog supply monitor enable |
| mon_dvdd_en | output | 1 | Digital supply monitor enable |

## Verification
The enables are tried with several mode words:
- all zero, the normal state;
- shutdown bit 0 alone, plain ADC shutdown;
- shutdown bit 0 with both external selects, full shutdown;
- both external selects without shutdown;
- shutdown bit 1 with both external selects.

These words separate the full-shutdown decode from the plain-shutdown decode and catch an OR used in place of an AND. A filter strobe is offered on every edge after a wake-up, which places the edge where results start to pass and the edge where they stop being suspect exactly. A hard reset asserted during operation shows that it clears settings that survive a shutdown, and that it forces the comparator state without waiting for a clock edge.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

    typedef struct packed {
        logic       clk_ext;
        logic       ref_ext;
        logic [1:0] shdn;
    } mode_t;

    typedef struct packed {
        logic adc_off;
        logic full_off;
    } pstate_t;

    localparam logic [1:0] A_MODE  = 2'd0;
    localparam logic [1:0] A_PHASE = 2'd1;
    localparam logic [1:0] A_BIAS  = 2'd2;
    localparam logic [1:0] A_FILT  = 2'd3;

    localparam logic [3:0] COMP_RST = 4'b0011;

    function automatic pstate_t decode_mode(mode_t m);
        pstate_t s;
        s.adc_off  = |m.shdn;
        s.full_off = m.shdn[0] & m.ref_ext & m.clk_ext;
        return s;
    endfunction

endpackage

// File: rtl/pwr_rst_sync.sv
module pwr_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic hold
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end

    assign hold = ~chain_q[STAGES-1];
endmodule

// File: rtl/pwr_cfg_regs.sv
module pwr_cfg_regs
    import pwr_mode_pkg::*;
#(
    parameter int REG_W    = 16,
    parameter int PH_W     = 8,
    parameter int BIAS_DEF = 4000,
    parameter int FILT_DEF = 32
) (
    input  logic             clk,
    input  logic             hold,
    input  logic             wr,
    input  logic [1:0]       addr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output mode_t            mode,
    output logic [PH_W-1:0]  phase,
    output logic [REG_W-1:0] bias_cnt,
    output logic [REG_W-1:0] filt_cnt
);
    localparam int MODE_W = $bits(mode_t);

    always_ff @(posedge clk) begin
        if (hold) begin
            mode     <= '0;
            phase    <= '0;
            bias_cnt <= REG_W'(BIAS_DEF);
            filt_cnt <= REG_W'(FILT_DEF);
        end else if (wr) begin
            case (addr)
                A_MODE:  mode     <= mode_t'(wdata[MODE_W-1:0]);
                A_PHASE: phase    <= wdata[PH_W-1:0];
                A_BIAS:  bias_cnt <= wdata;
                default: filt_cnt <= wdata;
            endcase
        end
    end

    always_comb begin
        case (addr)
            A_MODE:  rdata = {{(REG_W-MODE_W){1'b0}}, mode};
            A_PHASE: rdata = {{(REG_W-PH_W){1'b0}}, phase};
            A_BIAS:  rdata = bias_cnt;
            default: rdata = filt_cnt;
        endcase
    end
endmodule

// File: rtl/pwr_settle_timer.sv
module pwr_settle_timer #(
    parameter int REG_W = 16
) (
    input  logic             clk,
    input  logic             sleep,
    input  logic [REG_W-1:0] bias_cnt,
    input  logic [REG_W-1:0] filt_cnt,
    output logic             pass_ok,
    output logic             suspect
);
    localparam int CNT_W = REG_W + 1;

    logic [CNT_W-1:0] elapsed_q;
    logic [CNT_W-1:0] limit;

    assign limit = {1'b0, bias_cnt} + {1'b0, filt_cnt};

    always_ff @(posedge clk) begin
        if (sleep)                  elapsed_q <= '0;
        else if (elapsed_q < limit) elapsed_q <= elapsed_q + 1'b1;
    end

    assign pass_ok = elapsed_q >= {1'b0, filt_cnt};
    assign suspect = elapsed_q < limit;
endmodule

// File: rtl/pwr_out_gate.sv
module pwr_out_gate #(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              hold,
    input  logic              adc_off,
    input  logic              pass_ok,
    input  logic              suspect,
    input  logic [DATA_W-1:0] filt_data,
    input  logic              filt_drdy,
    output logic [DATA_W-1:0] dout,
    output logic              drdy,
    output logic              data_suspect
);
    logic [DATA_W-1:0] dout_q;
    logic              drdy_q;
    logic              sus_q;
    logic              quiet;
    logic              take;

    assign quiet = hold | adc_off;
    assign take  = filt_drdy & pass_ok;

    always_ff @(posedge clk) begin
        if (quiet) begin
            dout_q <= '0;
            drdy_q <= 1'b0;
            sus_q  <= 1'b0;
        end else begin
            drdy_q <= take;
            sus_q  <= take & suspect;
            if (take) dout_q <= filt_data;
        end
    end

    assign dout         = quiet ? '0 : dout_q;
    assign drdy         = drdy_q & ~quiet;
    assign data_suspect = sus_q & ~quiet;
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pwr_mode_pkg::*;
#(
    parameter int DATA_W          = 24,
    parameter int REG_W           = 16,
    parameter int PH_W            = 8,
    parameter int CORE_HZ         = 4_000_000,
    parameter int FILT_SETTLE_DEF = 32
) (
    input  logic              clk,
    input  logic              hrst_n,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_addr,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    output logic              cfg_ready,
    input  logic [3:0]        mod_comp,
    output logic [3:0]        comp_state,
    input  logic [DATA_W-1:0] filt_data,
    input  logic              filt_drdy,
    output logic              filt_rst,
    output logic [DATA_W-1:0] dout,
    output logic              drdy,
    output logic              data_suspect,
    output logic [PH_W-1:0]   phase_out,
    output logic              bias_en,
    output logic              clk_gate_en,
    output logic              iref_en,
    output logic              mon_avdd_en,
    output logic              mon_dvdd_en
);
    localparam int BIAS_DEF = CORE_HZ / 1000;

    logic             hold;
    mode_t            mode;
    pstate_t          pst;
    logic [REG_W-1:0] bias_cnt;
    logic [REG_W-1:0] filt_cnt;
    logic             pass_ok;
    logic             suspect;

    pwr_rst_sync #(.STAGES(2)) u_sync (
        .clk    (clk),
        .arst_n (hrst_n),
        .hold   (hold)
    );

    pwr_cfg_regs #(
        .REG_W    (REG_W),
        .PH_W     (PH_W),
        .BIAS_DEF (BIAS_DEF),
        .FILT_DEF (FILT_SETTLE_DEF)
    ) u_regs (
        .clk      (clk),
        .hold     (hold),
        .wr       (cfg_wr & cfg_ready),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .rdata    (cfg_rdata),
        .mode     (mode),
        .phase    (phase_out),
        .bias_cnt (bias_cnt),
        .filt_cnt (filt_cnt)
    );

    assign pst = decode_mode(mode);

    pwr_settle_timer #(.REG_W(REG_W)) u_timer (
        .clk      (clk),
        .sleep    (hold | pst.adc_off),
        .bias_cnt (bias_cnt),
        .filt_cnt (filt_cnt),
        .pass_ok  (pass_ok),
        .suspect  (suspect)
    );

    pwr_out_gate #(.DATA_W(DATA_W)) u_gate (
        .clk          (clk),
        .hold         (hold),
        .adc_off      (pst.adc_off),
        .pass_ok      (pass_ok),
        .suspect      (suspect),
        .filt_data    (filt_data),
        .filt_drdy    (filt_drdy),
        .dout         (dout),
        .drdy         (drdy),
        .data_suspect (data_suspect)
    );

    assign cfg_ready   = ~hold;
    assign filt_rst    = hold;
    assign comp_state  = hold ? COMP_RST : mod_comp;
    assign bias_en     = ~pst.adc_off;
    assign clk_gate_en = ~pst.adc_off;
    assign iref_en     = ~pst.full_off;
    assign mon_avdd_en = ~pst.full_off;
    assign mon_dvdd_en = ~pst.full_off;
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk #(
    parameter int DATA_W = 24,
    parameter int PH_W   = 8
) (
    input logic              clk,
    input logic              hrst_n,
    input logic              hold,
    input logic              adc_off,
    input logic              cfg_wr,
    input logic [1:0]        cfg_addr,
    input logic              cfg_ready,
    input logic [3:0]        comp_state,
    input logic              filt_drdy,
    input logic              filt_rst,
    input logic [DATA_W-1:0] dout,
    input logic              drdy,
    input logic [PH_W-1:0]   phase_out,
    input logic              mon_avdd_en,
    input logic              mon_dvdd_en
);
    p_reset_force_r1: assert property (@(posedge clk)
        !hrst_n |-> (comp_state == 4'b0011 && !cfg_ready && !drdy && filt_rst));

    p_sd_quiet_r4: assert property (@(posedge clk) disable iff (!hrst_n)
        adc_off |-> (!drdy && dout == '0));

    p_phase_keep_r5: assert property (@(posedge clk) disable iff (!hrst_n || hold)
        !(cfg_wr && cfg_ready && cfg_addr == 2'd1) |=> $stable(phase_out));

    p_mon_pair_r6: assert property (@(posedge clk) disable iff (!hrst_n)
        mon_avdd_en == mon_dvdd_en);

    p_drdy_src_r9: assert property (@(posedge clk) disable iff (!hrst_n || hold)
        drdy |-> $past(filt_drdy));
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(.DATA_W(DATA_W), .PH_W(PH_W)) u_chk (
    .clk         (clk),
    .hrst_n      (hrst_n),
    .hold        (hold),
    .adc_off     (pst.adc_off),
    .cfg_wr      (cfg_wr),
    .cfg_addr    (cfg_addr),
    .cfg_ready   (cfg_ready),
    .comp_state  (comp_state),
    .filt_drdy   (filt_drdy),
    .filt_rst    (filt_rst),
    .dout        (dout),
    .drdy        (drdy),
    .phase_out   (phase_out),
    .mon_avdd_en (mon_avdd_en),
    .mon_dvdd_en (mon_dvdd_en)
);

// File: tb/pwr_mode_ctrl_bench.sv
module pwr_mode_ctrl_bench;
    localparam int DW = 24;
    localparam int RW = 16;
    localparam int PW = 8;

    logic          clk = 1'b0;
    logic          hrst_n = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [1:0]    cfg_addr = '0;
    logic [RW-1:0] cfg_wdata = '0;
    logic [RW-1:0] cfg_rdata;
    logic          cfg_ready;
    logic [3:0]    mod_comp = 4'h0;
    logic [3:0]    comp_state;
    logic [DW-1:0] filt_data = '0;
    logic          filt_drdy = 1'b0;
    logic          filt_rst;
    logic [DW-1:0] dout;
    logic          drdy, data_suspect;
    logic [PW-1:0] phase_out;
    logic          bias_en, clk_gate_en, iref_en, mon_avdd_en, mon_dvdd_en;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    pwr_mode_ctrl u_pwr_mode_ctrl (
        .clk(clk), .hrst_n(hrst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_ready(cfg_ready),
        .mod_comp(mod_comp), .comp_state(comp_state), .filt_data(filt_data),
        .filt_drdy(filt_drdy), .filt_rst(filt_rst), .dout(dout), .drdy(drdy),
        .data_suspect(data_suspect), .phase_out(phase_out), .bias_en(bias_en),
        .clk_gate_en(clk_gate_en), .iref_en(iref_en),
        .mon_avdd_en(mon_avdd_en), .mon_dvdd_en(mon_dvdd_en)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [RW-1:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [1:0] a, input int exp, input string tag);
        cfg_addr = a;
        #1;
        chk(int'(cfg_rdata) == exp, tag, int'(cfg_rdata), exp);
    endtask

    task automatic strobe(input logic [DW-1:0] d);
        @(negedge clk);
        filt_drdy = 1'b1; filt_data = d;
        @(posedge clk);
        @(negedge clk);
        filt_drdy = 1'b0;
    endtask

    task automatic chk_en(input bit b, input bit c, input bit r, input bit m, input string tag);
        #1;
        chk(bias_en == b && clk_gate_en == c, {tag, " bias/clk"}, {bias_en, clk_gate_en}, {b, c});
        chk(iref_en == r && mon_avdd_en == m && mon_dvdd_en == m, {tag, " ref/mon"},
            {iref_en, mon_avdd_en, mon_dvdd_en}, {r, m, m});
    endtask

    task automatic t_reset_entry;
        #1;
        chk(comp_state == 4'b0011, "R1 comp forced", comp_state, 3);
        chk(!cfg_ready && !drdy && dout == 0 && filt_rst, "R1 quiet",
            {cfg_ready, drdy, filt_rst}, 3'b001);
        cfg_wr = 1'b1; cfg_addr = 2'd1; cfg_wdata = 16'h0055;
        @(posedge clk); @(negedge clk);
        cfg_wr = 1'b0;
        hrst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        chk(!cfg_ready, "R2 still held after 1 edge", cfg_ready, 0);
        @(posedge clk); @(negedge clk);
        chk(cfg_ready && !filt_rst, "R2 released after 2 edges", {cfg_ready, filt_rst}, 2'b10);
        rd_chk(2'd0, 0, "R2 mode default");
        rd_chk(2'd1, 0, "R2 phase write ignored");
        rd_chk(2'd2, 4000, "R2 bias default");
        rd_chk(2'd3, 32, "R2 filter default");
    endtask

    task automatic t_regs;
        wr_reg(2'd1, 16'h003C);
        rd_chk(2'd1, 16'h3C, "R3 phase reg");
        chk(phase_out == 8'h3C, "R3 phase_out", phase_out, 8'h3C);
        wr_reg(2'd2, 16'd10);
        wr_reg(2'd3, 16'd5);
        rd_chk(2'd2, 10, "R3 bias reg");
        rd_chk(2'd3, 5, "R3 filt reg");
        mod_comp = 4'hA;
        #1 chk(comp_state == 4'hA, "R10 comp pass", comp_state, 4'hA);
    endtask

    task automatic t_normal;
        repeat (20) @(negedge clk);
        chk_en(1, 1, 1, 1, "R4 normal");
        strobe(24'h123456);
        chk(drdy && dout == 24'h123456, "R9 pass strobe", dout, 24'h123456);
        chk(!data_suspect, "R8 settled", data_suspect, 0);
        @(negedge clk);
        chk(!drdy && dout == 24'h123456, "R9 single pulse hold", {drdy, dout}, 24'h123456);
    endtask

    task automatic t_adc_sd;
        wr_reg(2'd0, 16'h0001);
        chk_en(0, 0, 1, 1, "R4 adc sd");
        chk(dout == 0, "R4 dout zero", dout, 0);
        strobe(24'hABCDEF);
        chk(!drdy && dout == 0, "R4 strobe blocked", {drdy, dout}, 0);
        rd_chk(2'd1, 16'h3C, "R5 phase kept in sd");
        chk(phase_out == 8'h3C, "R5 phase_out kept", phase_out, 8'h3C);
        rd_chk(2'd2, 10, "R5 bias kept");
        wr_reg(2'd0, 16'h000E);
        chk_en(0, 0, 1, 1, "R6 shdn1 not full");
        wr_reg(2'd0, 16'h0000);
        chk_en(1, 1, 1, 1, "R4 wake enables");
        rd_chk(2'd3, 5, "R5 filt kept after wake");
        chk(phase_out == 8'h3C, "R5 phase after wake", phase_out, 8'h3C);
    endtask

    task automatic t_wake_settle;
        wr_reg(2'd0, 16'h0001);
        wr_reg(2'd0, 16'h0000);
        for (int k = 1; k <= 20; k++) begin
            filt_drdy = 1'b1; filt_data = DW'(k);
            @(posedge clk); @(negedge clk);
            chk(drdy == (k > 5), "R7 pass window", drdy, int'(k > 5));
            chk(data_suspect == (k > 5 && k <= 15), "R8 suspect window",
                data_suspect, int'(k > 5 && k <= 15));
        end
        filt_drdy = 1'b0;
    endtask

    task automatic t_full_sd;
        wr_reg(2'd0, 16'h000D);
        chk_en(0, 0, 0, 0, "R6 full sd");
        wr_reg(2'd0, 16'h000C);
        chk_en(1, 1, 1, 1, "R6 ext only");
        wr_reg(2'd0, 16'h0005);
        chk_en(0, 0, 1, 1, "R6 ref only");
        wr_reg(2'd0, 16'h000D);
        wr_reg(2'd0, 16'h0009);
        chk_en(0, 0, 1, 1, "R6 ref bit cleared");
        wr_reg(2'd0, 16'h0000);
    endtask

    task automatic t_reset_mid;
        wr_reg(2'd0, 16'h0001);
        #2 hrst_n = 1'b0;
        #1;
        chk(comp_state == 4'b0011 && !cfg_ready, "R1 mid reset", comp_state, 3);
        chk(filt_rst && !drdy, "R1 mid filt_rst", {filt_rst, drdy}, 2'b10);
        @(negedge clk); hrst_n = 1'b1;
        repeat (3) @(negedge clk);
        rd_chk(2'd1, 0, "R2 phase cleared");
        rd_chk(2'd0, 0, "R2 mode cleared");
        rd_chk(2'd3, 32, "R2 filt cleared");
    endtask

    initial begin
        t_reset_entry();
        t_regs();
        t_normal();
        t_adc_sd();
        t_wake_settle();
        t_full_sd();
        t_reset_mid();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1_000_000;
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule